// File: doc/BRIEF.md
# Detent Rotary Encoder Direction Decoder

This block turns the two raw phase lines of a mechanical detent encoder into one direction event per detent. Each line first passes a two-stage synchroniser. A single quiet-time counter then filters both lines together: any change on either line restarts it. The filtered phase pair drives a four-state sequence tracker, and that tracker reports a left or right event only when a full detent completes.

Each event updates two status bits that a polling host reads through a small read-only register port: a direction bit and a sticky new-event flag. The host polls the flag word. When the flag is set, it reads the direction word, and that read clears the flag. The lines idle high in a detent. A left detent walks the phase pair (A in bit 1, B in bit 0) through 11, 10, 00, 01, 11. A right detent walks it through 11, 01, 00, 10, 11.

The tracker has four states:
- `ST_REST` is the detent, where both lines are high.
- `ST_MID` is entered once both lines have been seen low.
- `ST_LEFT` is armed by 01 seen after the low point.
- `ST_RIGHT` is armed by 10 seen after the low point.

The transitions are:
- REST→MID on 00.
- MID→LEFT on 01, MID→RIGHT on 10, and MID→REST on 11, which aborts without an event.
- LEFT→REST on 11 with a left event, and RIGHT→REST on 11 with a right event.
- LEFT or RIGHT→MID on 00.
- LEFT→REST on 10 and RIGHT→REST on 01. These are illegal jumps and raise no event.
- Every other code keeps the current state.

Top module: `rot_detent_decoder`

## Requirements
- R1: Reset is synchronous and active low. After reset, the word at offset 0 and the word at offset 1 both read zero, the tracker is in the rest state, and the filtered phase pair is 11.
- R2: A phase change takes effect only after both lines have stayed unchanged for 2^(CNT_W-1) consecutive clock cycles. The status bits of a completed detent become visible exactly 2^(CNT_W-1)+3 rising edges after the first edge that samples the final phase change.
- R3: A bounce or glitch shorter than the quiet window restarts the quiet window. Such a pulse never reaches the tracker and raises no event.
- R4: A left detent (11, 10, 00, 01, 11) sets bit 0 of offset 0 to 0 (left) and bit 0 of offset 1 to 1. The event fires on the final 01→11 step.
- R5: A right detent (11, 01, 00, 10, 11) sets bit 0 of offset 0 to 1 (right) and sets the flag. The event fires on the final 10→11 step.
- R6: Aborted or illegal sequences raise no event, for example 11, 00, 11 or 11, 10, 11 or 11, 10, 00, 01, 10, 11. The direction bit keeps its value, and a following valid detent is still decoded.
- R7: Each completed detent raises exactly one event. Back-to-back detents each set the flag, and the direction bit always holds the most recent event's direction.
- R8: A read strobe at offset 0 clears the flag at the next edge. If an event lands in the same cycle, the set wins and the flag stays 1.
- R9: A read strobe at offset 1 does not clear the flag. Offsets 2 and 3 read zero, and all bits above bit 0 read zero.
- R10: The read data follows the address in the same cycle, with no strobe needed and no latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_a | input | 1 | Raw encoder phase A, asynchronous |
| phase_b | input | 1 | Raw encoder phase B, asynchronous |
| rd_en | input | 1 | Read strobe; with offset 0, it clears the flag |
| rd_addr | input | ADDR_W | Word offset of the register to read |
| rd_data | output | DATA_W | Read data for rd_addr |

## Verification
The bench builds the block with CNT_W = 4, which makes the quiet window 8 cycles. With a window that short, bounce bursts, sub-window glitches and exact-edge latency probes all fit in a few dozen cycles. The 2^(CNT_W-1)+3 edge latency can then be sampled one edge before and on the edge itself. The same short window lets the bench place a clearing read precisely on the cycle an event lands, which exercises the set-over-clear priority.

// File: rtl/rde_pkg.sv
package rde_pkg;

    // Tracker states of the detent sequence
    typedef enum logic [1:0] {
        ST_REST  = 2'd0,
        ST_MID   = 2'd1,
        ST_LEFT  = 2'd2,
        ST_RIGHT = 2'd3
    } rde_state_e;

    // Phase pair codes, A in bit 1, B in bit 0
    localparam logic [1:0] AB_IDLE  = 2'b11;
    localparam logic [1:0] AB_LOW   = 2'b00;
    localparam logic [1:0] AB_LARM  = 2'b01;
    localparam logic [1:0] AB_RARM  = 2'b10;

    localparam int NUM_PHASES = 2;

endpackage

// File: rtl/rde_phase_filter.sv
module rde_phase_filter
    import rde_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PHASES-1:0] raw_ab,
    output logic [NUM_PHASES-1:0] clean_ab
);

    localparam int MSB = CNT_W - 1;

    logic [NUM_PHASES-1:0] meta_q;
    logic [NUM_PHASES-1:0] samp_q;
    logic [NUM_PHASES-1:0] clean_q;
    logic [CNT_W-1:0]      quiet_q;
    logic                  any_edge;

    // Two-stage synchroniser per phase, idle level high
    generate
        for (genvar g = 0; g < NUM_PHASES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q[g] <= 1'b1;
                    samp_q[g] <= 1'b1;
                end else begin
                    meta_q[g] <= raw_ab[g];
                    samp_q[g] <= meta_q[g];
                end
            end
        end
    endgenerate

    assign any_edge = |(meta_q ^ samp_q);

    // Quiet-time counter: restarts on any edge, saturates once MSB is set
    always_ff @(posedge clk) begin
        if (!rst_n || any_edge) begin
            quiet_q <= '0;
        end else if (!quiet_q[MSB]) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    // Filtered outputs load the synchronised pair once the line is quiet
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean_q <= '1;
        end else if (quiet_q[MSB]) begin
            clean_q <= samp_q;
        end
    end

    assign clean_ab = clean_q;

    // R3: an edge between the synchroniser stages restarts the window
    assert_edge_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        any_edge |=> (quiet_q == '0));

    // R2: filtered pair changes only after a full quiet window
    assert_change_after_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clean_q) |-> $past(quiet_q[MSB]));

endmodule

// File: rtl/rde_detent_fsm.sv
module rde_detent_fsm
    import rde_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] clean_ab,
    output logic       evt_left,
    output logic       evt_right
);

    rde_state_e state_q;
    rde_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_REST;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_REST: begin
                if (clean_ab == AB_LOW) state_d = ST_MID;
            end
            ST_MID: begin
                if (clean_ab == AB_LARM)      state_d = ST_LEFT;
                else if (clean_ab == AB_RARM) state_d = ST_RIGHT;
                else if (clean_ab == AB_IDLE) state_d = ST_REST;
            end
            ST_LEFT: begin
                if (clean_ab == AB_IDLE)      state_d = ST_REST;
                else if (clean_ab == AB_LOW)  state_d = ST_MID;
                else if (clean_ab == AB_RARM) state_d = ST_REST;
            end
            ST_RIGHT: begin
                if (clean_ab == AB_IDLE)      state_d = ST_REST;
                else if (clean_ab == AB_LOW)  state_d = ST_MID;
                else if (clean_ab == AB_LARM) state_d = ST_REST;
            end
            default: state_d = ST_REST;
        endcase
    end

    // Event outputs
    always_comb begin
        evt_left  = 1'b0;
        evt_right = 1'b0;
        unique case (state_q)
            ST_LEFT:  evt_left  = (clean_ab == AB_IDLE);
            ST_RIGHT: evt_right = (clean_ab == AB_IDLE);
            default: begin
                evt_left  = 1'b0;
                evt_right = 1'b0;
            end
        endcase
    end

    // R4: the left-armed state is entered only from the low-point state
    assert_left_from_mid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEFT && $past(state_q) != ST_LEFT) |-> ($past(state_q) == ST_MID));

    // R5: the right-armed state is entered only from the low-point state
    assert_right_from_mid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RIGHT && $past(state_q) != ST_RIGHT) |-> ($past(state_q) == ST_MID));

    // R7: an event returns the tracker to rest, so one detent gives one event
    assert_event_then_rest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_left || evt_right) |=> (state_q == ST_REST));

endmodule

// File: rtl/rde_status_regs.sv
module rde_status_regs #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_left,
    input  logic              evt_right,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [ADDR_W-1:0] OFF_DIR  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_FLAG = ADDR_W'(1);

    logic dir_q;
    logic flag_q;
    logic evt_any;
    logic clr_req;

    assign evt_any = evt_left | evt_right;
    assign clr_req = rd_en && (rd_addr == OFF_DIR);

    // Direction bit: right = 1, left = 0, held between events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
        end else if (evt_right) begin
            dir_q <= 1'b1;
        end else if (evt_left) begin
            dir_q <= 1'b0;
        end
    end

    // Flag: set has priority over the clearing read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (evt_any) begin
            flag_q <= 1'b1;
        end else if (clr_req) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == OFF_DIR) begin
            rd_data[0] = dir_q;
        end else if (rd_addr == OFF_FLAG) begin
            rd_data[0] = flag_q;
        end
    end

    // R8: set wins over clear
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_any |=> flag_q);

    // R8: a clearing read with no event clears the flag
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == OFF_DIR && !evt_any) |=> !flag_q);

    // R5: a right event leaves the direction bit at 1
    assert_right_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_right |=> dir_q);

    // R4: a left event leaves the direction bit at 0
    assert_left_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_left |=> !dir_q);

    // R6: without an event the direction bit holds
    assert_dir_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_any |=> $stable(dir_q));

endmodule

// File: rtl/rot_detent_decoder.sv
module rot_detent_decoder
    import rde_pkg::*;
#(
    parameter int CNT_W  = 20,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase_a,
    input  logic              phase_b,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [NUM_PHASES-1:0] clean_ab;
    logic                  evt_left;
    logic                  evt_right;

    rde_phase_filter #(
        .CNT_W (CNT_W)
    ) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_ab   ({phase_a, phase_b}),
        .clean_ab (clean_ab)
    );

    rde_detent_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clean_ab  (clean_ab),
        .evt_left  (evt_left),
        .evt_right (evt_right)
    );

    rde_status_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_left  (evt_left),
        .evt_right (evt_right),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    // R7: the tracker never reports both directions in one cycle
    assert_single_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_left, evt_right}));

endmodule

// File: tb/rot_detent_decoder_tb.sv
module rot_detent_decoder_tb;

    localparam int CLK_P  = 10;
    localparam int CNT_W  = 4;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;
    localparam int WIN    = 1 << (CNT_W - 1);
    localparam int HOLD   = WIN + 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              phase_a = 1'b1;
    logic              phase_b = 1'b1;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    rot_detent_decoder #(
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_a (phase_a),
        .phase_b (phase_b),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always #(CLK_P/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    logic [1:0] r_prev, p1_v, p2_v, m_deb;
    bit         p1_ok, p2_ok;
    int         run;
    int         armed;      // -1 none, 0 low seen, 1 left armed, 2 right armed
    bit         ev_pend, ev_dir;
    bit         m_flag, m_dir;

    always @(posedge clk) begin
        logic [1:0] r;
        r = {phase_a, phase_b};
        if (!rst_n) begin
            r_prev = 2'b11; run = 1; p1_ok = 0; p2_ok = 0;
            p1_v = 2'b11; p2_v = 2'b11; m_deb = 2'b11;
            armed = -1; ev_pend = 0; ev_dir = 0; m_flag = 0; m_dir = 0;
        end else begin
            if (ev_pend) begin
                m_flag = 1; m_dir = ev_dir;
            end else if (rd_en && rd_addr == 0) begin
                m_flag = 0;
            end
            ev_pend = 0;
            if (p2_ok && p2_v != m_deb) begin
                m_deb = p2_v;
                if (m_deb == 2'b11) begin
                    if (armed == 1) begin ev_pend = 1; ev_dir = 0; end
                    else if (armed == 2) begin ev_pend = 1; ev_dir = 1; end
                    armed = -1;
                end else if (m_deb == 2'b00) begin
                    armed = 0;
                end else begin
                    int code;
                    code = (m_deb == 2'b01) ? 1 : 2;
                    if (armed == 0) armed = code;
                    else if (armed != code) armed = -1;
                end
            end
            p2_v = p1_v; p2_ok = p1_ok;
            if (r == r_prev) begin
                if (run < 100000) run = run + 1;
            end else begin
                run = 0;
            end
            r_prev = r;
            p1_v = r; p1_ok = (run >= WIN);
        end
    end

    // Per-clock comparison against the model
    always @(posedge clk) begin
        logic [DATA_W-1:0] exp_v;
        #(CLK_P/4);
        if (!done) begin
            exp_v = '0;
            if (rd_addr == 0) exp_v[0] = m_dir;
            else if (rd_addr == 1) exp_v[0] = m_flag;
            checks++;
            if (rd_data !== exp_v) begin
                errors++;
                $display("FAIL R10 per-cycle read data: actual %0h expected %0h at %0t",
                         rd_data, exp_v, $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp_v, $time);
        end
    endtask

    task automatic set_ab(input logic [1:0] c, input int cyc);
        @(negedge clk);
        {phase_a, phase_b} = c;
        repeat (cyc - 1) @(negedge clk);
    endtask

    task automatic step(input logic [1:0] c);
        set_ab(c, HOLD);
    endtask

    task automatic bouncy(input logic [1:0] from_c, input logic [1:0] to_c);
        set_ab(to_c, 2);
        set_ab(from_c, 1);
        set_ab(to_c, 3);
        set_ab(from_c, 2);
        set_ab(to_c, HOLD);
    endtask

    task automatic peek(input int addr, output int val);
        @(negedge clk);
        rd_en = 1'b0;
        rd_addr = ADDR_W'(addr);
        #1 val = int'(rd_data);
    endtask

    task automatic read_clear(output int dir_v);
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = '0;
        #1 dir_v = int'(rd_data);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic left_detent();
        step(2'b10); step(2'b00); step(2'b01); step(2'b11);
    endtask

    task automatic right_detent();
        step(2'b01); step(2'b00); step(2'b10); step(2'b11);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        int v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        peek(0, v); check(v == 0, "R1 direction after reset", v, 0);
        peek(1, v); check(v == 0, "R1 flag after reset", v, 0);
        // R9: unused offsets
        peek(2, v); check(v == 0, "R9 offset 2 reads zero", v, 0);
        peek(3, v); check(v == 0, "R9 offset 3 reads zero", v, 0);

        // R4: clean left detent
        left_detent();
        peek(1, v); check(v == 1, "R4 flag after left", v, 1);
        peek(1, v); check(v == 1, "R9 flag survives offset-1 access", v, 1);
        read_clear(v); check(v == 0, "R4 left direction", v, 0);
        peek(1, v); check(v == 0, "R8 flag cleared by direction read", v, 0);

        // R5 + R3: right detent with bouncing edges
        bouncy(2'b11, 2'b01); bouncy(2'b01, 2'b00);
        bouncy(2'b00, 2'b10); bouncy(2'b10, 2'b11);
        peek(1, v); check(v == 1, "R5 flag after bouncy right", v, 1);
        read_clear(v); check(v == 1, "R5 right direction", v, 1);

        // R3: short glitches at rest raise nothing
        set_ab(2'b00, WIN - 2); set_ab(2'b11, 2);
        set_ab(2'b10, WIN - 1); set_ab(2'b11, HOLD);
        peek(1, v); check(v == 0, "R3 sub-window glitch ignored", v, 0);

        // R6: aborted and illegal sequences
        step(2'b00); step(2'b11);
        step(2'b10); step(2'b11);
        step(2'b10); step(2'b00); step(2'b01); step(2'b10); step(2'b11);
        peek(1, v); check(v == 0, "R6 no event from aborts", v, 0);
        peek(0, v); check(v == 1, "R6 direction held", v, 1);
        left_detent();
        peek(1, v); check(v == 1, "R6 recovery detent flagged", v, 1);
        read_clear(v); check(v == 0, "R6 recovery detent left", v, 0);

        // R7: back-to-back detents
        for (int i = 0; i < 4; i++) begin
            if (i % 2 == 0) right_detent(); else left_detent();
            peek(1, v); check(v == 1, "R7 flag per detent", v, 1);
            read_clear(v); check(v == ((i % 2 == 0) ? 1 : 0), "R7 direction per detent", v,
                                 (i % 2 == 0) ? 1 : 0);
            peek(1, v); check(v == 0, "R7 flag cleared between detents", v, 0);
        end
        right_detent(); right_detent();
        peek(1, v); check(v == 1, "R7 flag after unread pair", v, 1);
        peek(0, v); check(v == 1, "R7 latest direction", v, 1);
        left_detent();
        peek(0, v); check(v == 0, "R7 direction follows latest", v, 0);
        read_clear(v);

        // R2: exact latency of the final step
        step(2'b01); step(2'b00); step(2'b10);
        @(negedge clk);
        rd_addr = 2'd1;
        {phase_a, phase_b} = 2'b11;
        repeat (WIN + 3) @(posedge clk);
        @(negedge clk);
        v = int'(rd_data);
        check(v == 0, "R2 flag not yet visible one edge early", v, 0);
        @(posedge clk);
        #1 v = int'(rd_data);
        check(v == 1, "R2 flag visible at window+3 edges", v, 1);
        read_clear(v); check(v == 1, "R2 right direction", v, 1);

        // R8: set wins over a clearing read in the same cycle
        step(2'b10); step(2'b00); step(2'b01);
        @(negedge clk);
        {phase_a, phase_b} = 2'b11;
        repeat (WIN + 3) @(posedge clk);
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = 2'd0;
        @(negedge clk);
        rd_en = 1'b0;
        rd_addr = 2'd1;
        #1 v = int'(rd_data);
        check(v == 1, "R8 set wins over clear", v, 1);
        peek(0, v); check(v == 0, "R8 left direction", v, 0);
        read_clear(v);
        peek(1, v); check(v == 0, "R8 later read clears", v, 0);

        // R10: address switches data in the same cycle
        @(negedge clk);
        rd_addr = 2'd0;
        #1 v = int'(rd_data);
        check(v == 0, "R10 immediate data", v, 0);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule